// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects level-sensitive request lines from on-chip peripherals, together with a 4-bit encoded level from an external requester, and presents one winning request to the processor. It reports the winner as a 12-bit event code and a 4-bit priority level. Peripheral sources are bound to priority groups at design time. Every member of a group takes its priority from the group's single 4-bit field, yet each member keeps its own event code. A group can hold, for example, the error, receive, transmit and end events of one serial unit.

Software sets the priorities by writing configuration words. Each word packs several 4-bit fields. The number of fields per word is a parameter: four fields gives a 16-bit word and eight fields gives a 32-bit word. Masking uses one address that sets mask bits and a second address that clears them, so neither write has to read and modify the register. The request chosen in a cycle is registered, and the CPU sees it at the outputs one clock edge later.

Top module: `grp_prio_intc`

## Requirements
- R1: During and after reset the outputs are zero (`irq_o`=0, `evt_code_o`=0, `level_o`=0). All group priorities reset to 0 and all mask bits reset to 0 (unmasked).
- R2: Configuration word r is written at address r, for r in 0..N_PREG-1. Field j of that word sets the priority of group r*FIELDS+j. Field 0 sits in the top bits `[4*FIELDS-1 : 4*FIELDS-4]`, and each following field sits 4 bits lower.
- R3: Source i takes its priority from the field of its group (SRC_GRP byte i). Its event code is always EVT_BASE + 0x20*i, whichever group it belongs to.
- R4: A source whose group priority is 0 never wins and never raises `irq_o`.
- R5: A write to address N_PREG sets the mask bit of every source whose data bit is 1. Data bits that are 0 leave their mask bits unchanged. A masked source never wins.
- R6: A write to address N_PREG+1 clears the mask bit of every source whose data bit is 1. Data bits that are 0 leave their mask bits unchanged.
- R7: The winner is the pending, unmasked request with the highest priority. When priorities are equal, the lower source index wins. The external request loses any tie with a peripheral source.
- R8: An external level k in 0..14 is a request with event code 0x200 + 0x20*k and priority 15-k. Level 15 means no external request. The mask does not apply to the external request.
- R9: The outputs change only at a clock edge. After each edge they show the selection made from the inputs and configuration present just before that edge.
- R10: When no request qualifies, `irq_o` is 0 and `evt_code_o` and `level_o` are both 0.
- R11: Writes to addresses above N_PREG+1 change neither the priorities nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Peripheral request lines, level sensitive |
| ext_lvl_i | input | 4 | Encoded external request level, 15 = none |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | ADDR_W | Configuration write address |
| wr_data_i | input | DATA_W | Configuration write data (max of 4*FIELDS and N_SRC) |
| irq_o | output | 1 | A request is being presented |
| evt_code_o | output | 12 | Event code of the presented request |
| level_o | output | 4 | Priority level of the presented request |

## Verification
The bench uses the default build: eight sources, two 16-bit configuration words with four fields each (eight groups), and a four-member shared group. At that size every one of the 256 request patterns can be run under four different priority layouts, both with and without an external request. All sixteen external codes can be run, and all 256 mask patterns can be pushed through the set address and then the clear address. Equal-priority ties, zero priorities and writes to unused addresses are aimed at directly.

// File: rtl/grp_prio_intc_pkg.sv
package grp_prio_intc_pkg;
  localparam int PRIO_W = 4;
  localparam int CODE_W = 12;
  localparam logic [CODE_W-1:0] CODE_STEP = 12'h020;
  localparam logic [CODE_W-1:0] EXT_BASE  = 12'h200;
  localparam logic [PRIO_W-1:0] EXT_NONE  = 4'hF;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
    logic [PRIO_W-1:0] level;
  } sel_t;
endpackage

// File: rtl/grp_prio_intc_cfg.sv
module grp_prio_intc_cfg
  import grp_prio_intc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_PREG = 2,
  parameter int FIELDS = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [N_PREG*FIELDS*PRIO_W-1:0] prio_o,
  output logic [N_SRC-1:0]           mask_o
);
  localparam int N_GRP = N_PREG * FIELDS;
  localparam logic [ADDR_W-1:0] MSET_A = ADDR_W'(N_PREG);
  localparam logic [ADDR_W-1:0] MCLR_A = ADDR_W'(N_PREG + 1);

  for (genvar g = 0; g < N_GRP; g++) begin : g_fld
    localparam int R = g / FIELDS;
    localparam int J = g % FIELDS;
    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(R);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_o[PRIO_W*g +: PRIO_W] <= '0;
      else if (wr_en_i && wr_addr_i == REG_A)
        prio_o[PRIO_W*g +: PRIO_W] <= wr_data_i[PRIO_W*(FIELDS-1-J) +: PRIO_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else if (wr_en_i && wr_addr_i == MSET_A) mask_o <= mask_o | wr_data_i[N_SRC-1:0];
    else if (wr_en_i && wr_addr_i == MCLR_A) mask_o <= mask_o & ~wr_data_i[N_SRC-1:0];
  end
endmodule

// File: rtl/grp_prio_intc_arb.sv
module grp_prio_intc_arb
  import grp_prio_intc_pkg::*;
#(
  parameter int                  N_SRC   = 8,
  parameter int                  N_GRP   = 8,
  parameter logic [N_SRC*8-1:0]  SRC_GRP = '0,
  parameter logic [CODE_W-1:0]   EVT_BASE = 12'h400
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC-1:0]        mask_i,
  input  logic [N_GRP*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       ext_lvl_i,
  output sel_t                    sel_o
);
  logic [PRIO_W-1:0] src_pri [N_SRC];
  logic [PRIO_W-1:0] ext_pri;

  // group lookup written as a scan so every field is a live input
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      src_pri[i] = '0;
      for (int g = 0; g < N_GRP; g++)
        if (SRC_GRP[8*i +: 8] == 8'(g)) src_pri[i] = prio_i[PRIO_W*g +: PRIO_W];
    end
  end

  assign ext_pri = EXT_NONE - ext_lvl_i;  // level 15 yields 0: never wins

  // strict '>' gives ties to the lowest index, external last
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && !mask_i[i] && src_pri[i] > sel_o.level) begin
        sel_o.valid = 1'b1;
        sel_o.level = src_pri[i];
        sel_o.code  = EVT_BASE + CODE_W'(i) * CODE_STEP;
      end
    end
    if (ext_pri > sel_o.level) begin
      sel_o.valid = 1'b1;
      sel_o.level = ext_pri;
      sel_o.code  = EXT_BASE + CODE_W'(ext_lvl_i) * CODE_STEP;
    end
  end
endmodule

// File: rtl/grp_prio_intc.sv
module grp_prio_intc
  import grp_prio_intc_pkg::*;
#(
  parameter int                 N_SRC    = 8,
  parameter int                 N_PREG   = 2,
  parameter int                 FIELDS   = 4,
  parameter int                 ADDR_W   = 3,
  parameter logic [N_SRC*8-1:0] SRC_GRP  = {8'd4, 8'd3, 8'd3, 8'd3, 8'd3, 8'd2, 8'd1, 8'd0},
  parameter logic [11:0]        EVT_BASE = 12'h400,
  localparam int                REG_W    = FIELDS * PRIO_W,
  localparam int                DATA_W   = (REG_W > N_SRC) ? REG_W : N_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [3:0]        ext_lvl_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o,
  output logic [11:0]       evt_code_o,
  output logic [3:0]        level_o
);
  localparam int N_GRP = N_PREG * FIELDS;

  logic [N_GRP*PRIO_W-1:0] prio;
  logic [N_SRC-1:0]        mask;
  sel_t                    sel_d, sel_q;

  grp_prio_intc_cfg #(
    .N_SRC(N_SRC), .N_PREG(N_PREG), .FIELDS(FIELDS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .prio_o(prio), .mask_o(mask)
  );

  grp_prio_intc_arb #(
    .N_SRC(N_SRC), .N_GRP(N_GRP), .SRC_GRP(SRC_GRP), .EVT_BASE(EVT_BASE)
  ) u_arb (
    .req_i(req_i), .mask_i(mask), .prio_i(prio),
    .ext_lvl_i(ext_lvl_i), .sel_o(sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  assign irq_o      = sel_q.valid;
  assign evt_code_o = sel_q.code;
  assign level_o    = sel_q.level;
endmodule

// File: rtl/grp_prio_intc_chk.sv
module grp_prio_intc_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [3:0]       ext_lvl_i,
  input logic             wr_en_i,
  input logic             irq_o,
  input logic [11:0]      evt_code_o,
  input logic [3:0]       level_o
);
  logic [1:0] edges;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            edges <= '0;
    else if (edges != 2'd3) edges <= edges + 2'd1;
  end

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (evt_code_o == 12'h000 && level_o == 4'h0));

  p_level_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> level_o != 4'h0);

  p_ext_served_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges != 2'd0 && $past(ext_lvl_i) != 4'hF) |->
      (irq_o && level_o >= 4'hF - $past(ext_lvl_i)));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges != 2'd0 && $past(req_i) == '0 && $past(ext_lvl_i) == 4'hF) |-> !irq_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges >= 2'd2 && $past(req_i) == $past(req_i, 2) &&
     $past(ext_lvl_i) == $past(ext_lvl_i, 2) && !$past(wr_en_i, 2)) |->
      (irq_o == $past(irq_o) && evt_code_o == $past(evt_code_o) &&
       level_o == $past(level_o)));
endmodule

bind grp_prio_intc grp_prio_intc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ext_lvl_i(ext_lvl_i),
  .wr_en_i(wr_en_i), .irq_o(irq_o), .evt_code_o(evt_code_o), .level_o(level_o)
);

// File: tb/grp_prio_intc_bench.sv
module grp_prio_intc_bench;
  localparam int N_SRC  = 8;
  localparam int N_PREG = 2;
  localparam int FIELDS = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_SRC-1:0]  req = '0;
  logic [3:0]        ext = 4'hF;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              irq;
  logic [11:0]       code;
  logic [3:0]        lvl;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  int bprio [8];
  logic [7:0] bmask = '0;

  always #5 clk = ~clk;

  grp_prio_intc u_grp_prio_intc (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .ext_lvl_i(ext),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_o(irq), .evt_code_o(code), .level_o(lvl)
  );

  function automatic int grp_of(input int i);
    if (i < 3) return i;
    if (i < 7) return 3;
    return 4;
  endfunction

  function automatic logic [16:0] model(input logic [7:0] r, input logic [3:0] e);
    int best = 0;
    logic [11:0] c = 12'h000;
    for (int i = 0; i < N_SRC; i++) begin
      int p = bprio[grp_of(i)];
      if (r[i] && !bmask[i] && p > best) begin
        best = p;
        c = 12'(12'h400 + 32 * i);
      end
    end
    if (e != 4'hF && (15 - int'(e)) > best) begin
      best = 15 - int'(e);
      c = 12'(12'h200 + 32 * int'(e));
    end
    return {best != 0, c, 4'(best)};
  endfunction

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h (req=%h ext=%0d)", tag, act, exp, req, ext);
    end
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(input int c);
    for (int g = 0; g < 8; g++) bprio[g] = (g * 7 + c * 5 + 3) % 16;
    for (int r = 0; r < N_PREG; r++)
      wr(r, {4'(bprio[4*r]), 4'(bprio[4*r+1]), 4'(bprio[4*r+2]), 4'(bprio[4*r+3])});
  endtask

  task automatic set_flat(input logic [3:0] p);
    for (int g = 0; g < 8; g++) bprio[g] = int'(p);
    wr(0, {4{p}});
    wr(1, {4{p}});
  endtask

  task automatic apply(input logic [7:0] r, input logic [3:0] e, input string tag);
    req = r; ext = e;
    @(negedge clk);
    chk(tag, {irq, code, lvl}, model(r, e));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 8; g++) bprio[g] = 0;
    req = 8'hFF;
    #23;
    chk("R1 in reset", {irq, code, lvl}, 17'h0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {irq, code, lvl}, 17'h0);
    apply(8'hFF, 4'hF, "R1 R4 zero priorities");

    // latency: source 5 (group 3) at level 1
    set_flat(4'h1);
    apply(8'h00, 4'hF, "R10 idle");
    req = 8'h20;
    #2;
    chk("R9 before edge", {irq, code, lvl}, 17'h0);
    @(negedge clk);
    chk("R9 after edge", {irq, code, lvl}, {1'b1, 12'h4A0, 4'h1});

    // R2 R3 R7 sweep over all request patterns
    for (int c = 0; c < 4; c++) begin
      set_all(c);
      for (int r = 0; r < 256; r++) begin
        apply(8'(r), 4'hF, "R2 R3 R7 R4");
        apply(8'(r), 4'((c * 4 + 2) % 15), "R7 R8 mixed");
      end
    end

    // R8 every external code, peripherals silent
    set_flat(4'h0);
    for (int k = 0; k < 16; k++) begin
      req = 8'hFF; ext = 4'(k);
      @(negedge clk);
      if (k == 15) chk("R8 none", {irq, code, lvl}, 17'h0);
      else chk("R8 code", {irq, code, lvl}, {1'b1, 12'(12'h200 + 32 * k), 4'(15 - k)});
    end

    // R7 ties
    set_flat(4'h5);
    req = 8'hA0; ext = 4'hF; @(negedge clk);
    chk("R7 tie low index", {irq, code, lvl}, {1'b1, 12'h4A0, 4'h5});
    req = 8'h00; ext = 4'd10; @(negedge clk);
    chk("R7 ext alone", {irq, code, lvl}, {1'b1, 12'h340, 4'h5});
    req = 8'h80; ext = 4'd10; @(negedge clk);
    chk("R7 ext loses tie", {irq, code, lvl}, {1'b1, 12'h4E0, 4'h5});
    req = 8'h80; ext = 4'd9; @(negedge clk);
    chk("R7 ext higher", {irq, code, lvl}, {1'b1, 12'h320, 4'h6});

    // R5 R6 mask set/clear sweep
    set_all(1);
    for (int m = 0; m < 256; m++) begin
      wr(2, DATA_W'(m));
      bmask = bmask | 8'(m);
      apply(8'hFF, 4'hF, "R5 mask set");
      wr(3, DATA_W'(m & 8'h55));
      bmask = bmask & ~8'(m & 8'h55);
      apply(8'hFF, 4'hF, "R6 mask clear");
    end
    wr(3, 16'h00FF); bmask = '0;
    apply(8'hFF, 4'hF, "R6 full clear");

    // R11 unused addresses
    wr(2, 16'h0011); bmask = 8'h11;
    for (int a = 4; a < 8; a++) begin
      wr(a, 16'hFFFF);
      apply(8'hFF, 4'hF, "R11 ignored write");
      apply(8'h0E, 4'hF, "R11 ignored write sub");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule